// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises a CPU interrupt after a programmed number of rendered video lines. Video timing sends it one pulse per scanline along with the number of that line and a flag that says whether background or sprite drawing is on. Only pulses for visible lines (0 through 239) that arrive while drawing is on are counted.

The CPU programs the block with byte writes. Four addresses are decoded through the mask 0xE001: one address sets the count directly, one sets a reload value, one arms the interrupt and one disarms it. The block looks at the count before it changes it. If a counted pulse finds the count at zero, the block copies the reload value into the count and raises the interrupt. If the count is not zero, the block subtracts one from it.

With reload value N, the interrupt therefore fires once every N+1 counted lines. The interrupt line stays high until the CPU disarms the block or a reset arrives.

Top module: `scanline_irq_counter`

## Requirements
- R1: A synchronous active-high reset clears the count, the reload value, the armed flag and `irq`. After reset, arming the block and sending one counted pulse raises `irq`, because the count is zero.
- R2: A write decodes `wr_addr & 16'hE001`. The result 16'hC000 loads `wr_data` into the count. The result 16'hC001 loads `wr_data` into the reload value. Address bits outside the mask are ignored.
- R3: A decoded 16'hE001 arms the block. A decoded 16'hE000 disarms it and drops `irq` on the next clock edge.
- R4: A pulse counts only when `line_pulse` is high, `line_num` is 239 or less, `render_on` is high and the block is armed. Any other pulse leaves the count unchanged.
- R5: A counted pulse that finds the count at zero loads the count from the reload value and raises `irq` on the clock edge that samples the pulse.
- R6: A counted pulse that finds a nonzero count subtracts one from the count and does not raise `irq`.
- R7: While the block is disarmed, scanline pulses leave the count unchanged. Counting resumes from the held value once the block is armed again.
- R8: Once high, `irq` stays high through further pulses and through any write except a decoded 16'hE000. Only that write or a reset lowers it.
- R9: With reload value N, after `irq` has been cleared and the block re-armed, `irq` rises again on exactly the (N+1)th counted pulse. This holds for N = 255 as well.
- R10: If a count write and a counted pulse fall in the same cycle, the write sets the count and the pulse is dropped.
- R11: Writes whose decoded address is none of the four above change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_pulse | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Number of the current scanline |
| render_on | input | 1 | High when background or sprite drawing is on |
| irq | output | 1 | Interrupt request, held until disarm or reset |

## Verification
The count is hidden: it shows at the ports only through the one pulse on which `irq` rises. Every hidden effect is therefore checked by where that rise lands. The count and the reload value are preloaded to small known values. Ignored pulses (line 240 and above, drawing off, block disarmed, or a pulse that collides with a count write) are mixed in ahead of counted ones. The check is that `irq` rises on exactly the pulse the arithmetic predicts, and on no earlier pulse. A sweep over every count and reload pair from 0 to 6, plus a reload value of 255, sets the repeat period. Aliased addresses and unused addresses are exercised the same way.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] DEC_MASK   = 16'hE001;
    localparam logic [ADDR_W-1:0] ADR_COUNT  = 16'hC000;
    localparam logic [ADDR_W-1:0] ADR_RELOAD = 16'hC001;
    localparam logic [ADDR_W-1:0] ADR_DISARM = 16'hE000;
    localparam logic [ADDR_W-1:0] ADR_ARM    = 16'hE001;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET_COUNT,
        OP_SET_RELOAD,
        OP_DISARM,
        OP_ARM
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [DATA_W-1:0] data;
    } cpu_op_t;

    function automatic op_e decode_op(input logic [ADDR_W-1:0] addr);
        logic [ADDR_W-1:0] masked;
        masked = addr & DEC_MASK;
        case (masked)
            ADR_COUNT:  return OP_SET_COUNT;
            ADR_RELOAD: return OP_SET_RELOAD;
            ADR_DISARM: return OP_DISARM;
            ADR_ARM:    return OP_ARM;
            default:    return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
    import sirq_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cpu_op_t           op_out
);
    always_comb begin
        op_out.data = wr_data;
        op_out.op   = wr_en ? decode_op(wr_addr) : OP_NONE;
    end
endmodule

// File: rtl/sirq_line_qual.sv
module sirq_line_qual #(
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 239
) (
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_on,
    output logic              visible_tick
);
    logic in_window;

    always_comb begin
        in_window    = (int'(line_num) <= LAST_LINE);
        visible_tick = line_pulse && render_on && in_window;
    end
endmodule

// File: rtl/sirq_counter.sv
module sirq_counter
    import sirq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cpu_op_t op_in,
    input  logic    visible_tick,
    output logic    irq
);
    localparam int CNT_W = DATA_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    logic             armed_q;
    logic             irq_q;
    logic             count_now;
    logic             at_zero;

    // a disarm in the same cycle wins over a pulse
    assign count_now = visible_tick && armed_q && (op_in.op != OP_DISARM);
    assign at_zero   = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            rld_q   <= '0;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            case (op_in.op)
                OP_DISARM: begin
                    armed_q <= 1'b0;
                    irq_q   <= 1'b0;
                end
                OP_ARM:        armed_q <= 1'b1;
                OP_SET_RELOAD: rld_q   <= op_in.data;
                default: ;
            endcase

            if (op_in.op == OP_SET_COUNT) begin
                cnt_q <= op_in.data;
            end else if (count_now) begin
                if (at_zero) begin
                    cnt_q <= rld_q;
                    irq_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign irq = irq_q;

    // R5: expiry reloads and raises the request
    assert_expiry_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (count_now && at_zero && op_in.op != OP_SET_COUNT) |=> (irq_q && cnt_q == $past(rld_q)));

    // R5: the request only rises out of an expiring pulse
    assert_rise_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(count_now && at_zero));

    // R6: a nonzero count steps down by one
    assert_step_down_R6: assert property (@(posedge clk) disable iff (rst)
        (count_now && !at_zero && op_in.op != OP_SET_COUNT) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7: a disarmed block holds its count
    assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && op_in.op != OP_SET_COUNT) |=> $stable(cnt_q));

    // R8: the request is sticky
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_q && op_in.op != OP_DISARM) |=> irq_q);

    // R3: disarm drops the request and the armed flag
    assert_disarm_R3: assert property (@(posedge clk) disable iff (rst)
        (op_in.op == OP_DISARM) |=> (!irq_q && !armed_q));

    // R10: a count write overrides a same-cycle pulse
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (op_in.op == OP_SET_COUNT) |=> (cnt_q == $past(op_in.data)));
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 239
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [sirq_pkg::ADDR_W-1:0]    wr_addr,
    input  logic [sirq_pkg::DATA_W-1:0]    wr_data,
    input  logic                           line_pulse,
    input  logic [LINE_W-1:0]              line_num,
    input  logic                           render_on,
    output logic                           irq
);
    import sirq_pkg::*;

    cpu_op_t op_w;
    logic    tick_w;

    sirq_decode u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .op_out  (op_w)
    );

    sirq_line_qual #(
        .LINE_W    (LINE_W),
        .LAST_LINE (LAST_LINE)
    ) u_qual (
        .line_pulse   (line_pulse),
        .line_num     (line_num),
        .render_on    (render_on),
        .visible_tick (tick_w)
    );

    sirq_counter u_count (
        .clk          (clk),
        .rst          (rst),
        .op_in        (op_w),
        .visible_tick (tick_w),
        .irq          (irq)
    );
endmodule

// File: tb/sim_scanline_irq_counter.sv
module sim_scanline_irq_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_pulse = 1'b0;
    logic [8:0]  line_num = '0;
    logic        render_on = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    scanline_irq_counter u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .line_pulse(line_pulse), .line_num(line_num), .render_on(render_on), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: irq actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic scan(input int ln, input bit rnd);
        @(negedge clk); line_pulse = 1'b1; line_num = 9'(ln); render_on = rnd;
        @(negedge clk); line_pulse = 1'b0; render_on = 1'b0;
    endtask

    task automatic scan_with_count_write(input int ln, input logic [7:0] d);
        @(negedge clk); line_pulse = 1'b1; line_num = 9'(ln); render_on = 1'b1;
        wr_en = 1'b1; wr_addr = 16'hC000; wr_data = d;
        @(negedge clk); line_pulse = 1'b0; render_on = 1'b0; wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        chk("R1 reset irq", irq, 0);
        // count and reload zero after reset: arm, one pulse fires
        cpu_wr(16'hE001, 8'h00);
        chk("R1 armed no pulse", irq, 0);
        scan(5, 1);
        chk("R1 zero count fires", irq, 1);
        // reset lowers a held request
        do_reset();
        chk("R1 reset drops irq", irq, 0);

        // R4: ignored pulses do not count
        do_reset();
        cpu_wr(16'hC001, 8'd7);
        cpu_wr(16'hC000, 8'd2);
        cpu_wr(16'hE001, 8'd0);
        scan(240, 1); chk("R4 line 240", irq, 0);
        scan(300, 1); chk("R4 line 300", irq, 0);
        scan(10, 0);  chk("R4 render off", irq, 0);
        scan(239, 1); chk("R4 line 239 counts", irq, 0);
        scan(0, 1);   chk("R4 line 0 counts", irq, 0);
        scan(100, 1); chk("R4 fire on third", irq, 1);

        // R7: disarmed block keeps its count
        do_reset();
        cpu_wr(16'hC000, 8'd3);
        for (int i = 0; i < 5; i++) begin
            scan(20 + i, 1); chk("R7 disarmed", irq, 0);
        end
        cpu_wr(16'hE001, 8'd0);
        scan(1, 1); scan(2, 1);
        cpu_wr(16'hE000, 8'd0);
        for (int i = 0; i < 4; i++) begin
            scan(50, 1); chk("R7 disarmed mid count", irq, 0);
        end
        cpu_wr(16'hE001, 8'd0);
        scan(3, 1); chk("R7 resume count 1 to 0", irq, 0);
        scan(4, 1); chk("R7 resume fire", irq, 1);

        // R8: sticky request
        for (int i = 0; i < 3; i++) begin
            scan(60 + i, 1); chk("R8 held over pulses", irq, 1);
        end
        cpu_wr(16'hE001, 8'd0); chk("R8 arm keeps irq", irq, 1);
        cpu_wr(16'hC000, 8'd9); chk("R8 count write keeps irq", irq, 1);
        cpu_wr(16'hC001, 8'd9); chk("R8 reload write keeps irq", irq, 1);
        cpu_wr(16'hE000, 8'd0); chk("R3 disarm clears irq", irq, 0);
        scan(70, 1); chk("R3 disarmed no count", irq, 0);

        // R2 aliasing and R11 unused addresses
        do_reset();
        cpu_wr(16'hDFFE, 8'd1);   // count
        cpu_wr(16'hDFFF, 8'd2);   // reload
        cpu_wr(16'hFFFF, 8'd0);   // arm
        scan(1, 1); chk("R2 alias count 1", irq, 0);
        scan(2, 1); chk("R2 alias fire", irq, 1);
        cpu_wr(16'hE002, 8'd0);   // disarm alias
        chk("R2 alias disarm", irq, 0);
        cpu_wr(16'hE001, 8'd0);
        cpu_wr(16'h8000, 8'd0);
        cpu_wr(16'hA000, 8'd0);
        cpu_wr(16'h6000, 8'd0);
        cpu_wr(16'h8001, 8'd0);
        scan(3, 1); chk("R11 unused writes", irq, 0);
        scan(4, 1); chk("R11 unused writes", irq, 0);
        scan(5, 1); chk("R11 reload kept", irq, 1);

        // R10: count write collides with counted pulse
        do_reset();
        cpu_wr(16'hE001, 8'd0);
        scan_with_count_write(8, 8'd4);
        chk("R10 pulse dropped", irq, 0);
        for (int i = 0; i < 4; i++) begin
            scan(9 + i, 1); chk("R10 counting down", irq, 0);
        end
        scan(30, 1); chk("R10 fire after write", irq, 1);

        // R5 R6 R9: sweep of count and reload
        for (int k = 0; k <= 6; k++) begin
            for (int n = 0; n <= 6; n++) begin
                do_reset();
                cpu_wr(16'hC001, 8'(n));
                cpu_wr(16'hC000, 8'(k));
                cpu_wr(16'hE001, 8'd0);
                for (int i = 0; i <= k; i++) begin
                    scan((i * 37) % 240, 1);
                    chk(i == k ? "R5 expiry" : "R6 step", irq, (i == k) ? 1 : 0);
                end
                cpu_wr(16'hE000, 8'd0);
                cpu_wr(16'hE001, 8'd0);
                for (int i = 0; i <= n; i++) begin
                    scan((i * 53) % 240, 1);
                    chk("R9 period", irq, (i == n) ? 1 : 0);
                end
            end
        end

        // R9: largest reload value
        do_reset();
        cpu_wr(16'hC001, 8'd255);
        cpu_wr(16'hE001, 8'd0);
        scan(0, 1); chk("R9 first fire", irq, 1);
        cpu_wr(16'hE000, 8'd0);
        cpu_wr(16'hE001, 8'd0);
        for (int i = 0; i <= 255; i++) begin
            scan(i % 240, 1);
            if (i == 254 || i == 255) chk("R9 period 256", irq, (i == 255) ? 1 : 0);
            else if (irq) chk("R9 early fire", irq, 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule